// File: doc/BRIEF.md
# SCSI Host Controller Register and Command Unit

This block is the byte-wide register file and command decoder of a simple SCSI host controller. A host reaches sixteen 8-bit registers through a register map with a 4-byte stride: the register index is taken from address bits [5:2], and bits [1:0] are ignored. The map holds a 16-bit transfer count split over two registers, a data port, a command register, read-only status, interrupt and sequence registers, and a set of configuration registers. One of the configuration registers stores only the bits of a fixed mask.

A write to the command register is decoded on the same clock edge. Bit 7 selects DMA mode. The low seven bits select the operation: flush, chip reset, bus reset, or an operation that is only recorded. The unit drives one level interrupt line. Reading the interrupt register acknowledges it: this clears the status register except its terminal-count bit and drops the line.

Other logic runs the select and transfer phases. When a phase ends, that logic reports the outcome on a one-cycle done strobe, which carries the status, interrupt and sequence bytes to latch. Two typical outcomes are a select to a missing target (status 0x80, interrupt 0x20, sequence 0x00) and a successful command phase (status 0x91, interrupt 0x18, sequence 0x04).

Top module: `scsi_ctl_top`

## Requirements
- R1: The register index is address bits [5:2]; address bits [1:0] have no effect. `rdata` combinationally shows the register selected by the current address.
- R2: After reset every register reads 0x00 except register 14, which reads 0x04. `irq` and `dma_mode` are 0.
- R3: A write stores the full byte into registers 0, 1 (transfer count low/high), 2, 3, 8, 12, 13, 14 and 15. A write to register 11 stores `wdata & 0x15`. Writes to registers 4, 5, 6, 7, 9 and 10 change nothing.
- R4: Every write to register 3 sets `dma_mode` to bit 7 of the written byte. The one exception is the chip reset command (R6), after which `dma_mode` is 0.
- R5: Command code 0x01 (low 7 bits) sets register 5 to 0x08 and register 6 to 0x00. It leaves `irq` unchanged.
- R6: Command code 0x02 returns every register, `irq` and `dma_mode` to the R2 values on that edge. This includes register 3 and applies whatever the value of bit 7.
- R7: Command code 0x03 sets register 5 to 0x80. It raises `irq` only if bit 6 of register 8 is 0 at that edge.
- R8: A read of register 5 (`rd_en` with index 5) leaves register 5 as it was. It sets register 4 to its old value AND 0x10 and drops `irq` on that edge.
- R9: A `done_valid` cycle loads registers 4, 5 and 6 from `done_status`, `done_intr` and `done_seq` and raises `irq`. It overrides a read clear or a command effect on the same edge.
- R10: Command code 0x00 and every code other than 0x01 to 0x03 store only the command byte and set the DMA mode bit. All other registers and `irq` stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (has an effect only for index 5) |
| addr | input | 6 | Byte address; index is bits [5:2] |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data from the addressed register |
| done_valid | input | 1 | Phase completion strobe |
| done_status | input | 8 | Status byte to latch on completion |
| done_intr | input | 8 | Interrupt byte to latch on completion |
| done_seq | input | 8 | Sequence byte to latch on completion |
| irq | output | 1 | Interrupt line, level |
| dma_mode | output | 1 | DMA mode selected by the last command |

## Verification
The state of this block is visible directly through `rdata`, `irq` and `dma_mode`, so a corrupted register or a wrong command effect shows on the next read of that register, one cycle after the offending edge. An interrupt flag left set or cleared in error shows on `irq` at the very next cycle. The bench keeps a model of the whole register file, and random traffic interleaves reads of every index with writes, commands and completions, so stale state is found within a few operations. Directed cases cover strobe collisions and the configuration bit that masks the bus-reset interrupt, because a wrong priority between sources only appears when two of them meet on one edge.

// File: rtl/scsi_ctl_pkg.sv
package scsi_ctl_pkg;

    localparam int REG_W = 8;

    localparam logic [3:0] IX_CNT_LO = 4'd0;
    localparam logic [3:0] IX_CNT_HI = 4'd1;
    localparam logic [3:0] IX_DATA   = 4'd2;
    localparam logic [3:0] IX_CMD    = 4'd3;
    localparam logic [3:0] IX_STAT   = 4'd4;
    localparam logic [3:0] IX_INTR   = 4'd5;
    localparam logic [3:0] IX_SEQ    = 4'd6;
    localparam logic [3:0] IX_CFG    = 4'd8;
    localparam logic [3:0] IX_CFGM   = 4'd11;
    localparam logic [3:0] IX_ID     = 4'd14;

    localparam logic [7:0] STAT_KEEP   = 8'h10;
    localparam logic [7:0] INTR_FLUSH  = 8'h08;
    localparam logic [7:0] INTR_BUSRST = 8'h80;
    localparam logic [7:0] CFGM_MASK   = 8'h15;
    localparam logic [7:0] ID_VALUE    = 8'h04;
    localparam int         CFG_IRQ_OFF = 6;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_NOP,
        OP_FLUSH,
        OP_CHIPRST,
        OP_BUSRST,
        OP_OTHER
    } cmd_op_e;

    typedef struct packed {
        logic    valid;
        logic    dma;
        cmd_op_e op;
    } cmd_req_t;

    typedef struct packed {
        logic [REG_W-1:0] status;
        logic [REG_W-1:0] intr;
        logic [REG_W-1:0] seq;
    } phase_t;

    // Bits a host write may store into each register.
    function automatic logic [REG_W-1:0] store_mask(input logic [3:0] idx);
        case (idx)
            IX_CNT_LO, IX_CNT_HI, IX_DATA, IX_CMD, IX_CFG,
            4'd12, 4'd13, 4'd14, 4'd15: store_mask = 8'hFF;
            IX_CFGM:                    store_mask = CFGM_MASK;
            default:                    store_mask = 8'h00;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] reset_value(input logic [3:0] idx);
        reset_value = (idx == IX_ID) ? ID_VALUE : 8'h00;
    endfunction

    function automatic cmd_op_e decode_op(input logic [6:0] code);
        case (code)
            7'h00:   decode_op = OP_NOP;
            7'h01:   decode_op = OP_FLUSH;
            7'h02:   decode_op = OP_CHIPRST;
            7'h03:   decode_op = OP_BUSRST;
            default: decode_op = OP_OTHER;
        endcase
    endfunction

endpackage

// File: rtl/scsi_ctl_cmd_dec.sv
module scsi_ctl_cmd_dec
    import scsi_ctl_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output cmd_req_t         cmd
);

    always_comb begin
        cmd.valid = wr_en && (idx == IX_CMD);
        cmd.dma   = wdata[7];
        cmd.op    = cmd.valid ? decode_op(wdata[6:0]) : OP_NONE;
    end

endmodule

// File: rtl/scsi_ctl_regbank.sv
module scsi_ctl_regbank
    import scsi_ctl_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    input  cmd_req_t         cmd,
    input  logic             done_valid,
    input  phase_t           done_ph,
    output logic [7:0]       rdata,
    output logic             irq,
    output logic             dma_mode
);

    localparam int NREG = 1 << IDX_W;

    logic [7:0] regs [NREG];
    logic       rd_intr;
    logic       chip_rst;
    logic       bus_rst;
    logic       flush;
    logic [7:0] wmask;

    assign rd_intr  = rd_en && (idx == IX_INTR);
    assign chip_rst = cmd.valid && (cmd.op == OP_CHIPRST);
    assign bus_rst  = cmd.valid && (cmd.op == OP_BUSRST);
    assign flush    = cmd.valid && (cmd.op == OP_FLUSH);
    assign wmask    = store_mask(idx);
    assign rdata    = regs[idx];

    always_ff @(posedge clk) begin
        if (rst || chip_rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= reset_value(IDX_W'(i));
            end
        end else begin
            if (wr_en && (wmask != 8'h00)) begin
                regs[idx] <= wdata & wmask;
            end
            if (flush) begin
                regs[IX_INTR] <= INTR_FLUSH;
                regs[IX_SEQ]  <= 8'h00;
            end
            if (bus_rst) begin
                regs[IX_INTR] <= INTR_BUSRST;
            end
            if (rd_intr) begin
                regs[IX_STAT] <= regs[IX_STAT] & STAT_KEEP;
            end
            if (done_valid) begin
                regs[IX_STAT] <= done_ph.status;
                regs[IX_INTR] <= done_ph.intr;
                regs[IX_SEQ]  <= done_ph.seq;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || chip_rst) begin
            irq <= 1'b0;
        end else if (done_valid) begin
            irq <= 1'b1;
        end else if (rd_intr) begin
            irq <= 1'b0;
        end else if (bus_rst && !regs[IX_CFG][CFG_IRQ_OFF]) begin
            irq <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || chip_rst) begin
            dma_mode <= 1'b0;
        end else if (cmd.valid) begin
            dma_mode <= cmd.dma;
        end
    end

    // R9: completion raises the line and latches the status byte
    assert_done_latch_R9: assert property (@(posedge clk) disable iff (rst)
        (done_valid && !chip_rst) |=> (irq && regs[IX_STAT] == $past(done_ph.status)));

    // R8: acknowledge clears status except terminal count and drops the line
    assert_ack_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_intr && !done_valid && !chip_rst) |=> (!irq && (regs[IX_STAT] & ~STAT_KEEP) == 8'h00));

    // R6: chip reset restores the identification value and clears the line
    assert_chip_reset_R6: assert property (@(posedge clk) disable iff (rst)
        chip_rst |=> (regs[IX_ID] == ID_VALUE && regs[IX_CMD] == 8'h00 && !irq && !dma_mode));

    // R7: masked bus reset never raises the line on its own
    assert_busrst_masked_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rst && regs[IX_CFG][CFG_IRQ_OFF] && !irq && !done_valid) |=> !irq);

    // R3: the masked configuration register never holds bits outside its mask
    assert_cfgm_mask_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == IX_CFGM) |=> ((regs[IX_CFGM] & ~CFGM_MASK) == 8'h00));

    // R4: a non-reset command sets DMA mode from bit 7
    assert_dma_bit_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd.valid && !chip_rst) |=> (dma_mode == $past(wdata[7])));

endmodule

// File: rtl/scsi_ctl_top.sv
module scsi_ctl_top
    import scsi_ctl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              done_valid,
    input  logic [7:0]        done_status,
    input  logic [7:0]        done_intr,
    input  logic [7:0]        done_seq,
    output logic              irq,
    output logic              dma_mode
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    cmd_req_t         cmd;
    phase_t           done_ph;
    logic             unused_lsb;

    assign idx        = addr[ADDR_W-1:2];
    assign unused_lsb = ^addr[1:0];
    assign done_ph    = '{status: done_status, intr: done_intr, seq: done_seq};

    scsi_ctl_cmd_dec #(.IDX_W(IDX_W)) i_cmd_dec (
        .wr_en (wr_en),
        .idx   (idx),
        .wdata (wdata),
        .cmd   (cmd)
    );

    scsi_ctl_regbank #(.IDX_W(IDX_W)) i_regbank (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .idx        (idx),
        .wdata      (wdata),
        .cmd        (cmd),
        .done_valid (done_valid),
        .done_ph    (done_ph),
        .rdata      (rdata),
        .irq        (irq),
        .dma_mode   (dma_mode)
    );

endmodule

// File: tb/test_scsi_ctl_top.sv
module test_scsi_ctl_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       done_valid = 1'b0;
    logic [7:0] done_status = '0;
    logic [7:0] done_intr = '0;
    logic [7:0] done_seq = '0;
    logic       irq;
    logic       dma_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] m_reg [16];
    bit m_irq;
    bit m_dma;

    always #4 clk = ~clk;

    scsi_ctl_top i_scsi_ctl_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .done_valid(done_valid),
        .done_status(done_status), .done_intr(done_intr), .done_seq(done_seq),
        .irq(irq), .dma_mode(dma_mode)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic m_reset();
        for (int i = 0; i < 16; i++) m_reg[i] = (i == 14) ? 8'h04 : 8'h00;
        m_irq = 0;
        m_dma = 0;
    endtask

    task automatic m_write(input int idx, input logic [7:0] d);
        case (idx)
            0, 1, 2, 8, 12, 13, 14, 15: m_reg[idx] = d;
            11: m_reg[idx] = d & 8'h15;
            3: begin
                m_reg[3] = d;
                m_dma = d[7];
                case (d[6:0])
                    7'h01: begin m_reg[5] = 8'h08; m_reg[6] = 8'h00; end
                    7'h02: m_reset();
                    7'h03: begin
                        m_reg[5] = 8'h80;
                        if (!m_reg[8][6]) m_irq = 1;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    endtask

    task automatic m_read(input int idx);
        if (idx == 5) begin
            m_reg[4] = m_reg[4] & 8'h10;
            m_irq = 0;
        end
    endtask

    task automatic m_done(input logic [7:0] s, input logic [7:0] i, input logic [7:0] q);
        m_reg[4] = s; m_reg[5] = i; m_reg[6] = q; m_irq = 1;
    endtask

    task automatic wr(input int idx, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; addr = {4'(idx), 2'($urandom % 4)}; wdata = d;
        @(posedge clk); #1;
        wr_en = 0;
        m_write(idx, d);
    endtask

    task automatic rd(input int idx, input string req);
        @(negedge clk);
        rd_en = 1; addr = {4'(idx), 2'($urandom % 4)};
        #1 chk(req, rdata, m_reg[idx]);
        @(posedge clk); #1;
        rd_en = 0;
        m_read(idx);
    endtask

    task automatic done(input logic [7:0] s, input logic [7:0] i, input logic [7:0] q);
        @(negedge clk);
        done_valid = 1; done_status = s; done_intr = i; done_seq = q;
        @(posedge clk); #1;
        done_valid = 0;
        m_done(s, i, q);
    endtask

    task automatic chk_lines(input string req);
        @(negedge clk);
        chk({req, " irq"}, {7'd0, irq}, {7'd0, m_irq});
        chk({req, " dma_mode"}, {7'd0, dma_mode}, {7'd0, m_dma});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        m_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R2: reset state of every register and line
        for (int i = 0; i < 16; i++) rd(i, "R2 reset value");
        chk_lines("R2");

        // R1: low address bits select nothing extra
        @(negedge clk); wr_en = 1; addr = {4'd12, 2'b11}; wdata = 8'hA5;
        @(posedge clk); #1 wr_en = 0; m_write(12, 8'hA5);
        @(negedge clk); addr = {4'd12, 2'b00};
        #1 chk("R1 alias read", rdata, 8'hA5);

        // R3: masked register, ignored registers, transfer count
        wr(11, 8'hFF); rd(11, "R3 masked reg 11");
        wr(4, 8'h5A); wr(7, 8'h33); wr(9, 8'h77); rd(4, "R3 status write ignored");
        rd(9, "R3 reg 9 write ignored");
        wr(0, 8'h34); wr(1, 8'h12); rd(0, "R3 count low"); rd(1, "R3 count high");

        // R4 and R10: unknown code keeps state, sets DMA mode
        done(8'h91, 8'h18, 8'h04);
        wr(3, 8'hFE); chk_lines("R4 R10 unknown code");
        rd(4, "R10 status kept"); rd(6, "R10 seq kept"); rd(3, "R10 cmd stored");
        wr(3, 8'h00); chk_lines("R4 NOP clears dma");

        // R8: acknowledge keeps terminal count only
        rd(5, "R8 intr value"); rd(4, "R8 status after ack"); rd(5, "R8 intr kept");
        chk_lines("R8 line low");

        // R5: flush
        wr(3, 8'h81); rd(5, "R5 flush intr"); rd(6, "R5 flush seq"); chk_lines("R5");

        // R7: bus reset with and without the disable bit
        wr(8, 8'h40); wr(3, 8'h03); chk_lines("R7 masked"); rd(5, "R7 intr masked");
        wr(8, 8'h00); wr(3, 8'h03); chk_lines("R7 unmasked");
        rd(5, "R7 intr"); chk_lines("R7 ack");

        // R9: completion on the same edge as acknowledge
        done(8'h80, 8'h20, 8'h00);
        @(negedge clk);
        rd_en = 1; addr = {4'd5, 2'b00}; done_valid = 1;
        done_status = 8'h91; done_intr = 8'h18; done_seq = 8'h04;
        #1 chk("R9 read before collide", rdata, m_reg[5]);
        @(posedge clk); #1 rd_en = 0; done_valid = 0;
        m_read(5); m_done(8'h91, 8'h18, 8'h04);
        chk_lines("R9 collide"); rd(4, "R9 status wins");

        // R6: chip reset with bit 7 set
        wr(13, 8'hC3); wr(3, 8'h82);
        for (int i = 0; i < 16; i++) rd(i, "R6 chip reset");
        chk_lines("R6");

        // Random traffic
        for (int n = 0; n < 1500; n++) begin
            int sel;
            sel = $urandom % 10;
            if (sel < 4) begin
                int idx;
                logic [7:0] d;
                idx = $urandom % 16;
                d = 8'($urandom);
                if (idx == 3) begin
                    case ($urandom % 6)
                        0: d = {d[7], 7'h01};
                        1: d = {d[7], 7'h02};
                        2: d = {d[7], 7'h03};
                        3: d = {d[7], 7'h00};
                        default: ;
                    endcase
                end
                wr(idx, d);
            end else if (sel < 8) begin
                rd($urandom % 16, "R1 R3 R8 random read");
            end else if (sel == 8) begin
                done(8'($urandom), 8'($urandom), 8'($urandom));
            end else begin
                chk_lines("R4 R7 R9 random lines");
            end
        end

        finish_run();
    end

endmodule